// File: doc/BRIEF.md
# Barrel-Threaded Dispatch Scheduler

This block decides, on every clock cycle, which of a pool of hardware threads sends its next instruction into a deep in-order pipeline. That pipeline has no forwarding paths and cannot stall. Correct results therefore depend entirely on spacing: a thread that has issued is held back until its instruction has retired, or until a fixed re-issue gap has elapsed. The pipeline is kept full by rotating among the other threads in that time.

Each thread carries two bits of state, running and busy, plus a small countdown. A control side starts and stops threads with one bit per thread. The tail of the pipeline returns a completion pulse that carries a thread number. Each cycle the block shows a dispatch-valid flag and the chosen thread number. When no thread can go, the flag is low and a bubble enters the pipeline. With at least as many running threads as the re-issue gap, one instruction goes out on every cycle.

Top module: `barrel_dispatch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `disp_valid` is 0 and `disp_tid` is 0. No thread is running after reset.
- R2: A thread whose bit is set in `start_mask` at a clock edge is running from the next cycle. If it is not busy, it can be dispatched in that cycle.
- R3: A thread whose bit is set in `stop_mask` at a clock edge is never dispatched from the next cycle on. When the same bit is set in both masks in the same cycle, the stop wins.
- R4: Only a thread that is running and not busy is dispatched. At most one thread is dispatched per cycle.
- R5: A dispatched thread is busy from the next cycle. If no completion arrives, it becomes eligible again exactly REISSUE_GAP cycles (default 11) after its dispatch, and never sooner.
- R6: A completion pulse (`done_valid` high with `done_tid`) presented in cycle c for a busy thread clears its busy state, so the thread can be dispatched in cycle c+1.
- R7: Among eligible threads, the one picked is the first in ascending index order, with wrap-around, after the last thread that was dispatched. After reset the search starts at thread 0.
- R8: With no completions and N running threads, the block dispatches min(N, REISSUE_GAP) instructions in every window of REISSUE_GAP cycles once it is in steady state. With N at or above REISSUE_GAP, it dispatches on every cycle.
- R9: In a cycle with no eligible thread, `disp_valid` is 0 and `disp_tid` is 0. When `disp_valid` is 1, `disp_tid` is below NUM_THREADS.
- R10: A thread stopped while its instruction is in flight still has its busy state cleared by that instruction's completion. If it is restarted, it can then be dispatched before its re-issue gap has run out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_mask | input | NUM_THREADS (24) | One bit per thread: make the thread running |
| stop_mask | input | NUM_THREADS (24) | One bit per thread: halt the thread; overrides start |
| done_valid | input | 1 | Completion pulse from the pipeline tail |
| done_tid | input | TID_W (5) | Thread number of the completing instruction |
| disp_valid | output | 1 | A thread issues in this cycle |
| disp_tid | output | TID_W (5) | Number of the issuing thread, 0 when none |

## Verification
The dispatch outputs are decoded from registered state. A start or stop presented at an edge shows up in the cycle right after it, and a completion in cycle c frees its thread for cycle c+1. With no completions, a single thread reappears exactly every REISSUE_GAP cycles; with the stub pipeline returning completions after four stages, it reappears every five. The bench drives inputs just after the falling edge and reads outputs at the next falling edge, so each expected value is compared in the exact cycle it is due. Rates are counted over windows of REISSUE_GAP multiples, where the expected count follows directly from the number of running threads.

// File: rtl/barrel_sched_pkg.sv
package barrel_sched_pkg;

   // width of a thread index, never below one bit
   function automatic int tid_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // width of the re-issue countdown (holds gap-2)
   function automatic int gap_cnt_width(input int gap);
      return (gap > 2) ? $clog2(gap) : 1;
   endfunction

   typedef enum logic [1:0] {
      SLOT_IDLE    = 2'b00,
      SLOT_READY   = 2'b01,
      SLOT_WAIT    = 2'b10,
      SLOT_DRAIN   = 2'b11
   } slot_view_e;

endpackage

// File: rtl/barrel_thread_slot.sv
module barrel_thread_slot
   import barrel_sched_pkg::*;
#(
   parameter int REISSUE_GAP = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   input  logic stop_req,
   input  logic issue,
   input  logic retire,
   output logic running,
   output logic busy,
   output logic eligible
);

   localparam int CNT_W = gap_cnt_width(REISSUE_GAP);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(REISSUE_GAP - 2);

   logic             run_q;
   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;

   // run flag: stop takes priority over start
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
      end else if (stop_req) begin
         run_q <= 1'b0;
      end else if (start_req) begin
         run_q <= 1'b1;
      end
   end

   // busy flag with countdown; a retire pulse frees early
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (issue) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_LOAD;
      end else if (busy_q) begin
         if (retire || (cnt_q == '0)) begin
            busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   slot_view_e view;
   always_comb begin
      unique case ({busy_q, run_q})
         2'b00:   view = SLOT_IDLE;
         2'b01:   view = SLOT_READY;
         2'b11:   view = SLOT_WAIT;
         default: view = SLOT_DRAIN;
      endcase
   end

   assign running  = run_q;
   assign busy     = busy_q;
   assign eligible = (view == SLOT_READY);

endmodule

// File: rtl/barrel_rr_pick.sv
module barrel_rr_pick #(
   parameter int NUM_REQ = 24,
   parameter int IDX_W   = 5
) (
   input  logic [NUM_REQ-1:0] req,
   input  logic [IDX_W-1:0]   last,
   output logic               gnt_valid,
   output logic [IDX_W-1:0]   gnt_idx
);

   // search starts one past the last winner and wraps
   always_comb begin
      gnt_valid = 1'b0;
      gnt_idx   = '0;
      for (int k = 1; k <= NUM_REQ; k++) begin
         automatic int cand = int'(last) + k;
         if (cand >= NUM_REQ) cand = cand - NUM_REQ;
         if (!gnt_valid && req[cand]) begin
            gnt_valid = 1'b1;
            gnt_idx   = IDX_W'(cand);
         end
      end
   end

endmodule

// File: rtl/barrel_dispatch.sv
module barrel_dispatch
   import barrel_sched_pkg::*;
#(
   parameter int NUM_THREADS = 24,
   parameter int REISSUE_GAP = 11,
   parameter int TID_W       = tid_width(NUM_THREADS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_THREADS-1:0] start_mask,
   input  logic [NUM_THREADS-1:0] stop_mask,
   input  logic                   done_valid,
   input  logic [TID_W-1:0]       done_tid,
   output logic                   disp_valid,
   output logic [TID_W-1:0]       disp_tid
);

   localparam logic [TID_W-1:0] LAST_INIT = TID_W'(NUM_THREADS - 1);

   // elaboration-time parameter checks
   if (NUM_THREADS < 2) begin : g_bad_threads
      $error("barrel_dispatch: NUM_THREADS must be at least 2");
   end
   if (REISSUE_GAP < 2) begin : g_bad_gap
      $error("barrel_dispatch: REISSUE_GAP must be at least 2");
   end
   if (TID_W < tid_width(NUM_THREADS)) begin : g_bad_tidw
      $error("barrel_dispatch: TID_W too narrow for NUM_THREADS");
   end

   logic [NUM_THREADS-1:0] active_vec;
   logic [NUM_THREADS-1:0] busy_vec;
   logic [NUM_THREADS-1:0] ready_vec;
   logic [NUM_THREADS-1:0] issue_vec;
   logic [NUM_THREADS-1:0] retire_vec;
   logic [TID_W-1:0]       last_q;
   logic                   pick_valid;
   logic [TID_W-1:0]       pick_idx;

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_slot
      assign issue_vec[t]  = pick_valid && (pick_idx == TID_W'(t));
      assign retire_vec[t] = done_valid && (done_tid == TID_W'(t));

      barrel_thread_slot #(
         .REISSUE_GAP (REISSUE_GAP)
      ) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .start_req (start_mask[t]),
         .stop_req  (stop_mask[t]),
         .issue     (issue_vec[t]),
         .retire    (retire_vec[t]),
         .running   (active_vec[t]),
         .busy      (busy_vec[t]),
         .eligible  (ready_vec[t])
      );
   end

   barrel_rr_pick #(
      .NUM_REQ (NUM_THREADS),
      .IDX_W   (TID_W)
   ) u_pick (
      .req       (ready_vec),
      .last      (last_q),
      .gnt_valid (pick_valid),
      .gnt_idx   (pick_idx)
   );

   // remember the last winner for the rotation
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q <= LAST_INIT;
      end else if (pick_valid) begin
         last_q <= pick_idx;
      end
   end

   assign disp_valid = pick_valid;
   assign disp_tid   = pick_idx;

endmodule

// File: rtl/barrel_dispatch_chk.sv
module barrel_dispatch_chk #(
   parameter int NUM_THREADS = 24,
   parameter int REISSUE_GAP = 11,
   parameter int TID_W       = 5
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_THREADS-1:0] stop_mask,
   input logic                   done_valid,
   input logic [TID_W-1:0]       done_tid,
   input logic                   disp_valid,
   input logic [TID_W-1:0]       disp_tid,
   input logic [NUM_THREADS-1:0] active_vec,
   input logic [NUM_THREADS-1:0] busy_vec
);

   localparam int SINCE_W = $clog2(REISSUE_GAP + 1);

   logic [NUM_THREADS-1:0] stop_prev;
   always_ff @(posedge clk) begin
      if (!rst_n) stop_prev <= '0;
      else        stop_prev <= stop_mask;
   end

   // R4: only a running, idle thread goes out
   assert_ready_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> (active_vec[disp_tid] && !busy_vec[disp_tid]));

   // R5: a dispatched thread is held busy in the next cycle
   assert_busy_after_R5: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |=> busy_vec[$past(disp_tid)]);

   // R3: a stop seen at the last edge silences that thread
   assert_stop_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> !stop_prev[disp_tid]);

   // R9: idle outputs are zero, busy outputs in range
   assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_valid |-> (disp_tid == '0));
   assert_tid_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> (int'(disp_tid) < NUM_THREADS));

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      logic               iss;
      logic               ret;
      logic [SINCE_W-1:0] since_q;
      logic               freed_q;

      assign iss = disp_valid && (disp_tid == TID_W'(t));
      assign ret = done_valid && (done_tid == TID_W'(t));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            since_q <= SINCE_W'(REISSUE_GAP);
            freed_q <= 1'b1;
         end else if (iss) begin
            since_q <= SINCE_W'(1);
            freed_q <= 1'b0;
         end else begin
            if (since_q < SINCE_W'(REISSUE_GAP)) since_q <= since_q + 1'b1;
            if (ret) freed_q <= 1'b1;
         end
      end

      // R5: never two instructions of one thread in flight
      assert_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
         iss |-> (freed_q || (since_q >= SINCE_W'(REISSUE_GAP))));

      // R6: completion on a busy thread frees it next cycle
      assert_retire_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (ret && busy_vec[t]) |=> !busy_vec[t]);
   end

endmodule

bind barrel_dispatch barrel_dispatch_chk #(
   .NUM_THREADS (NUM_THREADS),
   .REISSUE_GAP (REISSUE_GAP),
   .TID_W       (TID_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stop_mask  (stop_mask),
   .done_valid (done_valid),
   .done_tid   (done_tid),
   .disp_valid (disp_valid),
   .disp_tid   (disp_tid),
   .active_vec (active_vec),
   .busy_vec   (busy_vec)
);

// File: tb/barrel_dispatch_test.sv
module stub_pipe #(
   parameter int LAT = 4,
   parameter int TW  = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_v,
   input  logic [TW-1:0] in_tid,
   output logic          out_v,
   output logic [TW-1:0] out_tid
);
   logic          v_q   [LAT];
   logic [TW-1:0] tid_q [LAT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < LAT; s++) begin
            v_q[s]   <= 1'b0;
            tid_q[s] <= '0;
         end
      end else begin
         v_q[0]   <= in_v;
         tid_q[0] <= in_tid;
         for (int s = 1; s < LAT; s++) begin
            v_q[s]   <= v_q[s-1];
            tid_q[s] <= tid_q[s-1];
         end
      end
   end

   assign out_v   = v_q[LAT-1];
   assign out_tid = tid_q[LAT-1];
endmodule

module barrel_dispatch_test;

   localparam int NT   = 24;
   localparam int GAP  = 11;
   localparam int TW   = 5;
   localparam int SLAT = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NT-1:0] start_mask = '0;
   logic [NT-1:0] stop_mask = '0;
   logic          comp_en = 1'b0;
   logic          stub_v;
   logic [TW-1:0] stub_tid;
   logic          done_valid;
   logic          disp_valid;
   logic [TW-1:0] disp_tid;

   always #4 clk = ~clk;

   assign done_valid = comp_en && stub_v;

   barrel_dispatch #(.NUM_THREADS(NT), .REISSUE_GAP(GAP)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_mask (start_mask),
      .stop_mask  (stop_mask),
      .done_valid (done_valid),
      .done_tid   (stub_tid),
      .disp_valid (disp_valid),
      .disp_tid   (disp_tid)
   );

   stub_pipe #(.LAT(SLAT), .TW(TW)) u_stub (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_v   (disp_valid),
      .in_tid (disp_tid),
      .out_v  (stub_v),
      .out_tid(stub_tid)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int disp_cnt = 0;
   int last_iss [NT];
   bit freed    [NT];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // per-cycle monitor: in-flight spacing (R5, R6) and idle outputs (R9)
   initial begin
      for (int i = 0; i < NT; i++) begin
         last_iss[i] = -1000;
         freed[i] = 1'b1;
      end
      forever begin
         @(negedge clk);
         cyc++;
         if (rst_n) begin
            if (disp_valid) begin
               chk(freed[disp_tid] || (cyc - last_iss[disp_tid] >= GAP),
                   "R5 in-flight spacing", cyc - last_iss[disp_tid], GAP);
               last_iss[disp_tid] = cyc;
               freed[disp_tid] = 1'b0;
               disp_cnt++;
            end else begin
               chk(disp_tid == '0, "R9 idle tid", int'(disp_tid), 0);
            end
            if (done_valid) freed[stub_tid] = 1'b1;
         end
      end
   end

   task automatic cw();
      @(negedge clk);
      #1;
   endtask

   task automatic pulse_start(input logic [NT-1:0] m);
      start_mask = m;
      cw();
      start_mask = '0;
   endtask

   task automatic stop_all();
      stop_mask = '1;
      cw();
      stop_mask = '0;
      repeat (GAP + 1) cw();
   endtask

   task automatic expect_disp(input bit v, input int tid, input string req);
      chk(disp_valid == v, req, int'(disp_valid), int'(v));
      if (v) chk(int'(disp_tid) == tid, req, int'(disp_tid), tid);
   endtask

   initial begin
      int exp_seq[12];
      int s, got, ex, t0;

      // R1: reset state
      repeat (3) begin
         cw();
         expect_disp(1'b0, 0, "R1 in reset");
         chk(disp_tid == '0, "R1 tid in reset", int'(disp_tid), 0);
      end
      rst_n = 1'b1;
      cw();
      expect_disp(1'b0, 0, "R1 after reset");

      // R7/R8: all threads, strict rotation from thread 0
      pulse_start('1);
      for (int k = 0; k < 48; k++) begin
         expect_disp(1'b1, k % NT, "R7 full rotation");
         cw();
      end
      stop_all();

      // R2/R5: one thread, timer-only re-issue every GAP cycles
      pulse_start(NT'(1) << 5);
      expect_disp(1'b1, 5, "R2 start visible next cycle");
      for (int k = 1; k <= 2 * GAP; k++) begin
         cw();
         expect_disp((k % GAP) == 0, 5, "R5 re-issue gap");
      end

      // R3: stop silences the thread
      stop_mask = NT'(1) << 5;
      cw();
      stop_mask = '0;
      for (int k = 0; k < 15; k++) begin
         expect_disp(1'b0, 0, "R3 stopped thread silent");
         cw();
      end
      // R3: start and stop together, stop wins
      start_mask = NT'(1) << 7;
      stop_mask  = NT'(1) << 7;
      cw();
      start_mask = '0;
      stop_mask  = '0;
      for (int k = 0; k < 5; k++) begin
         expect_disp(1'b0, 0, "R3 stop beats start");
         cw();
      end

      // R7: sparse set, search resumes after last winner (5)
      exp_seq = '{9, 17, 2, -1, -1, -1, -1, -1, -1, -1, -1, 9};
      pulse_start((NT'(1) << 2) | (NT'(1) << 9) | (NT'(1) << 17));
      for (int k = 0; k < 12; k++) begin
         expect_disp(exp_seq[k] >= 0, exp_seq[k], "R7 sparse order");
         cw();
      end
      stop_all();

      // R8: throughput sweep, timer-only
      for (int n = 1; n <= NT; n++) begin
         pulse_start(NT'((64'd1 << n) - 1));
         repeat (2 * GAP) cw();
         s = disp_cnt;
         repeat (10 * GAP) cw();
         got = disp_cnt - s;
         ex = ((n < GAP) ? n : GAP) * 10;
         chk(got == ex, "R8 dispatch rate", got, ex);
         stop_all();
      end

      // R6: completions from stub pipeline free threads early
      comp_en = 1'b1;
      repeat (SLAT + 1) cw();
      pulse_start(NT'(1) << 3);
      expect_disp(1'b1, 3, "R6 first issue");
      for (int k = 1; k <= 20; k++) begin
         cw();
         expect_disp((k % (SLAT + 1)) == 0, 3, "R6 completion re-issue");
      end
      stop_all();
      pulse_start(NT'(7));
      repeat (10) cw();
      s = disp_cnt;
      repeat (100) cw();
      got = disp_cnt - s;
      chk(got == 60, "R6 rate with completions", got, 60);
      stop_all();

      // R10: stopped thread in flight still retires
      pulse_start(NT'(1) << 6);
      expect_disp(1'b1, 6, "R10 issue");
      t0 = cyc;
      stop_mask = NT'(1) << 6;
      cw();
      stop_mask = '0;
      expect_disp(1'b0, 0, "R10 stopped");
      cw();
      expect_disp(1'b0, 0, "R10 stopped");
      cw();
      expect_disp(1'b0, 0, "R10 stopped");
      cw();
      expect_disp(1'b0, 0, "R10 stopped");
      start_mask = NT'(1) << 6;
      cw();
      start_mask = '0;
      expect_disp(1'b1, 6, "R10 restart after completion");
      chk(cyc - t0 == SLAT + 1, "R10 early re-issue", cyc - t0, SLAT + 1);
      comp_en = 1'b0;
      stop_all();

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule